// File: doc/BRIEF.md
# Error Severity Controller

This block gathers error pulses from a parameterised set of sources and classifies each one by a programmable 2-bit severity and a float-enable bit held per source. Every event leaves a sticky per-source status bit. It also sets one of three sticky summary flags: critical, noncritical or notification. A three-state controller (normal, alarm, fault) turns these events into four system actions: a reset request, a heartbeat enable, an I/O float command and an interrupt request.

Per-source settings are written through a plain write port that takes an index, a severity and a float bit. Status bits are cleared by writing ones on a clear port. When a critical error arrives, the state moves to FAULT one edge after the critical flag is raised, and FAULT is left only by reset. A noncritical error raises ALARM and the interrupt at once. Clearing the status bits of every noncritical source returns the controller to normal.

Top module: `err_sev_ctrl`

## Requirements
- R1: Each source has a severity setting (00 critical, 01 reserved, 10 noncritical, 11 notification) and a float bit, written when cfg_we is high for source cfg_idx; after reset every source is notification with float off.
- R2: An error pulse on any source sets that source's bit of esf at the next clock edge, whatever its severity.
- R3: esf bits are cleared at a clock edge where clr_we is high and the matching clr_mask bit is 1; a new error on the same source in that cycle wins and the bit stays set.
- R4: sum_crit, sum_noncrit and sum_notif are set at the edge that samples an error of that severity and stay set until reset.
- R5: Once sum_crit is set, state becomes FAULT (encoding 2) at the following edge.
- R6: In FAULT, rst_req is 1, rst_flag is 1, hb_en is 0 and io_float is 1; rst_flag stays 1 and FAULT is left only by reset.
- R7: A noncritical error moves state to ALARM (encoding 1) at the edge that samples it; irq is 1 exactly while state is ALARM.
- R8: A noncritical or notification error sets io_float at the sampling edge only if that source's float bit is 1; io_float then holds until reset.
- R9: A notification error changes neither state nor irq.
- R10: An error from a source set to the reserved code sets only its esf bit: no summary flag, no state change, no io_float.
- R11: In ALARM, once no source set to noncritical has its esf bit set, state returns to NORMAL (encoding 0) at the next edge and irq drops.
- R12: Priority: a critical error in ALARM still leads to FAULT; a noncritical error in FAULT leaves FAULT unchanged; when critical and noncritical errors come in the same cycle, the state does not pass through ALARM but goes from NORMAL to FAULT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_in | input | N_SRC | One error pulse bit per source |
| cfg_we | input | 1 | Write strobe for one source's setting |
| cfg_idx | input | IDXW | Source index being written |
| cfg_sev | input | 2 | Severity code to store |
| cfg_float | input | 1 | Float-enable bit to store |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | N_SRC | Status bits to clear (write one to clear) |
| esf | output | N_SRC | Sticky per-source status bits |
| sum_crit | output | 1 | Critical error seen |
| sum_noncrit | output | 1 | Noncritical error seen |
| sum_notif | output | 1 | Notification error seen |
| state | output | 2 | Controller state: 0 normal, 1 alarm, 2 fault |
| rst_req | output | 1 | System reset request |
| rst_flag | output | 1 | Sticky reset cause flag |
| hb_en | output | 1 | Heartbeat enable |
| io_float | output | 1 | Float all I/O pads |
| irq | output | 1 | Interrupt / NMI request |

## Verification
Status bits, summary flags, ALARM, irq and a float request from a lower severity are all due one edge after the error cycle. FAULT, rst_req, rst_flag, the loss of hb_en and the fault-driven float are due one edge later. A return from ALARM appears one edge after the edge that clears the status bits. The bench drives inputs on the falling edge and samples on the falling edge that follows each of these rising edges. It sweeps every source, severity code and float bit, and after each error it checks both sampling points.

// File: rtl/err_sev_pkg.sv
package err_sev_pkg;
   typedef enum logic [1:0] {
      ST_NORMAL = 2'd0,
      ST_ALARM  = 2'd1,
      ST_FAULT  = 2'd2
   } ctl_state_e;

   localparam logic [1:0] SEV_CRIT    = 2'b00;
   localparam logic [1:0] SEV_RSVD    = 2'b01;
   localparam logic [1:0] SEV_NONCRIT = 2'b10;
   localparam logic [1:0] SEV_NOTIF   = 2'b11;
endpackage

// File: rtl/err_sev_cfg.sv
module err_sev_cfg
   import err_sev_pkg::*;
#(
   parameter int         N_SRC     = 8,
   parameter int         IDXW      = 3,
   parameter logic [1:0] RST_SEV   = SEV_NOTIF,
   parameter bit         RST_FLOAT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [IDXW-1:0]  cfg_idx,
   input  logic [1:0]       cfg_sev,
   input  logic             cfg_float,
   input  logic [N_SRC-1:0] err_in,
   output logic             crit_hit,
   output logic             ncrit_hit,
   output logic             notif_hit,
   output logic             float_hit,
   output logic [N_SRC-1:0] ncrit_mask
);
   logic [N_SRC-1:0] crit_v, ncrit_v, notif_v, float_v;

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      logic [1:0] sev_q;
      logic       flt_q;
      logic       sel;

      assign sel = cfg_we && (cfg_idx == IDXW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sev_q <= RST_SEV;
            flt_q <= RST_FLOAT;
         end else if (sel) begin
            sev_q <= cfg_sev;
            flt_q <= cfg_float;
         end
      end

      assign crit_v[g]     = err_in[g] && (sev_q == SEV_CRIT);
      assign ncrit_v[g]    = err_in[g] && (sev_q == SEV_NONCRIT);
      assign notif_v[g]    = err_in[g] && (sev_q == SEV_NOTIF);
      assign float_v[g]    = flt_q && (ncrit_v[g] || notif_v[g]);
      assign ncrit_mask[g] = (sev_q == SEV_NONCRIT);
   end

   assign crit_hit  = |crit_v;
   assign ncrit_hit = |ncrit_v;
   assign notif_hit = |notif_v;
   assign float_hit = |float_v;
endmodule

// File: rtl/err_sev_flags.sv
module err_sev_flags #(
   parameter int N_SRC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] err_in,
   input  logic             clr_we,
   input  logic [N_SRC-1:0] clr_mask,
   input  logic             crit_hit,
   input  logic             ncrit_hit,
   input  logic             notif_hit,
   output logic [N_SRC-1:0] esf,
   output logic             sum_crit,
   output logic             sum_noncrit,
   output logic             sum_notif
);
   logic [N_SRC-1:0] clr_eff;

   assign clr_eff = clr_we ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         esf         <= '0;
         sum_crit    <= 1'b0;
         sum_noncrit <= 1'b0;
         sum_notif   <= 1'b0;
      end else begin
         esf         <= (esf & ~clr_eff) | err_in;
         sum_crit    <= sum_crit    | crit_hit;
         sum_noncrit <= sum_noncrit | ncrit_hit;
         sum_notif   <= sum_notif   | notif_hit;
      end
   end

   AST_ESF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_in) |=> ((esf & $past(err_in)) == $past(err_in))); // R2
   AST_CRIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      sum_crit |=> sum_crit); // R4
endmodule

// File: rtl/err_sev_fsm.sv
module err_sev_fsm
   import err_sev_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       crit_flag,
   input  logic       crit_hit,
   input  logic       ncrit_hit,
   input  logic       float_hit,
   input  logic       ncrit_pending,
   output ctl_state_e state_q,
   output logic       rst_req,
   output logic       rst_flag,
   output logic       hb_en,
   output logic       io_float,
   output logic       irq
);
   ctl_state_e state_d;

   always_comb begin
      state_d = state_q;
      if (state_q != ST_FAULT) begin
         if (crit_flag)
            state_d = ST_FAULT;
         else if (crit_hit)
            state_d = state_q;
         else if (ncrit_hit)
            state_d = ST_ALARM;
         else if ((state_q == ST_ALARM) && !ncrit_pending)
            state_d = ST_NORMAL;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_NORMAL;
         rst_flag <= 1'b0;
         io_float <= 1'b0;
      end else begin
         state_q  <= state_d;
         rst_flag <= rst_flag | (state_d == ST_FAULT);
         io_float <= io_float | float_hit | (state_d == ST_FAULT);
      end
   end

   assign rst_req = (state_q == ST_FAULT);
   assign hb_en   = (state_q != ST_FAULT);
   assign irq     = (state_q == ST_ALARM);

   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != 2'd3); // R6
   AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FAULT) |=> (state_q == ST_FAULT)); // R6
   AST_FAULT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FAULT) |-> (io_float && rst_flag)); // R6
   AST_FLOAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      io_float |=> io_float); // R8
endmodule

// File: rtl/err_sev_ctrl.sv
module err_sev_ctrl
   import err_sev_pkg::*;
#(
   parameter int         N_SRC     = 8,
   parameter int         IDXW      = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   parameter logic [1:0] RST_SEV   = SEV_NOTIF,
   parameter bit         RST_FLOAT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] err_in,
   input  logic             cfg_we,
   input  logic [IDXW-1:0]  cfg_idx,
   input  logic [1:0]       cfg_sev,
   input  logic             cfg_float,
   input  logic             clr_we,
   input  logic [N_SRC-1:0] clr_mask,
   output logic [N_SRC-1:0] esf,
   output logic             sum_crit,
   output logic             sum_noncrit,
   output logic             sum_notif,
   output logic [1:0]       state,
   output logic             rst_req,
   output logic             rst_flag,
   output logic             hb_en,
   output logic             io_float,
   output logic             irq
);
   localparam int MIN_IDXW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   if (N_SRC < 1 || N_SRC > 64) begin : g_bad_n
      $error("err_sev_ctrl: N_SRC must be 1..64");
   end
   if (IDXW < MIN_IDXW) begin : g_bad_idx
      $error("err_sev_ctrl: IDXW too narrow for N_SRC");
   end

   logic             crit_hit, ncrit_hit, notif_hit, float_hit;
   logic [N_SRC-1:0] ncrit_mask;
   ctl_state_e       st;

   err_sev_cfg #(
      .N_SRC(N_SRC), .IDXW(IDXW), .RST_SEV(RST_SEV), .RST_FLOAT(RST_FLOAT)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_sev(cfg_sev), .cfg_float(cfg_float), .err_in(err_in),
      .crit_hit(crit_hit), .ncrit_hit(ncrit_hit), .notif_hit(notif_hit),
      .float_hit(float_hit), .ncrit_mask(ncrit_mask)
   );

   err_sev_flags #(.N_SRC(N_SRC)) u_flags (
      .clk(clk), .rst_n(rst_n), .err_in(err_in), .clr_we(clr_we),
      .clr_mask(clr_mask), .crit_hit(crit_hit), .ncrit_hit(ncrit_hit),
      .notif_hit(notif_hit), .esf(esf), .sum_crit(sum_crit),
      .sum_noncrit(sum_noncrit), .sum_notif(sum_notif)
   );

   err_sev_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .crit_flag(sum_crit), .crit_hit(crit_hit),
      .ncrit_hit(ncrit_hit), .float_hit(float_hit),
      .ncrit_pending(|(esf & ncrit_mask)), .state_q(st),
      .rst_req(rst_req), .rst_flag(rst_flag), .hb_en(hb_en),
      .io_float(io_float), .irq(irq)
   );

   assign state = st;

   AST_CRIT_TO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      sum_crit |=> (state == 2'd2)); // R5
   AST_ALARM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd1) |-> (sum_noncrit && irq)); // R7
   AST_FAULT_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd2) |-> (rst_req && !hb_en && io_float)); // R6
endmodule

// File: tb/err_sev_ctrl_tb.sv
module err_sev_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 4;
   localparam int IW         = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  err_in = '0;
   logic          cfg_we = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic [1:0]    cfg_sev = '0;
   logic          cfg_float = 1'b0;
   logic          clr_we = 1'b0;
   logic [N-1:0]  clr_mask = '0;
   logic [N-1:0]  esf;
   logic          sum_crit, sum_noncrit, sum_notif;
   logic [1:0]    state;
   logic          rst_req, rst_flag, hb_en, io_float, irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   err_sev_ctrl #(.N_SRC(N), .IDXW(IW)) u_dut (
      .clk(clk), .rst_n(rst_n), .err_in(err_in), .cfg_we(cfg_we),
      .cfg_idx(cfg_idx), .cfg_sev(cfg_sev), .cfg_float(cfg_float),
      .clr_we(clr_we), .clr_mask(clr_mask), .esf(esf), .sum_crit(sum_crit),
      .sum_noncrit(sum_noncrit), .sum_notif(sum_notif), .state(state),
      .rst_req(rst_req), .rst_flag(rst_flag), .hb_en(hb_en),
      .io_float(io_float), .irq(irq)
   );

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; err_in = '0; cfg_we = 1'b0; clr_we = 1'b0; clr_mask = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic write_cfg(input int idx, input logic [1:0] sev, input logic flt);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_sev = sev; cfg_float = flt;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // drive one error cycle; returns just after the sampling edge
   task automatic pulse(input logic [N-1:0] v);
      @(negedge clk);
      err_in = v;
      @(negedge clk);
      err_in = '0;
   endtask

   task automatic clear_all();
      @(negedge clk);
      clr_we = 1'b1; clr_mask = '1;
      @(negedge clk);
      clr_we = 1'b0; clr_mask = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      @(negedge clk);
      // reset state, R6 outputs idle
      check("R6 reset state", {30'd0, state}, 0);
      check("R6 reset rst_req/flag/hb", {29'd0, rst_req, rst_flag, hb_en}, 3'b001);
      check("R8 reset io_float", io_float, 0);
      check("R7 reset irq", irq, 0);
      check("R4 reset summaries", {sum_crit, sum_noncrit, sum_notif}, 0);
      check("R2 reset esf", esf, 0);

      // R1 reset setting is notification, float off
      pulse(4'b0100);
      check("R1 default sev notif", {sum_crit, sum_noncrit, sum_notif}, 3'b001);
      check("R1 default float off", io_float, 0);
      check("R9 default no state change", state, 0);

      // sweep: every source, severity code, float bit
      for (int i = 0; i < N; i++) begin
         for (int s = 0; s < 4; s++) begin
            for (int f = 0; f < 2; f++) begin
               bit is_c, is_n, is_t;
               is_c = (s == 0); is_n = (s == 2); is_t = (s == 3);
               do_reset();
               write_cfg(i, 2'(s), 1'(f));
               pulse(N'(1) << i);
               // one edge after error
               check("R2 esf bit set", esf, N'(1) << i);
               check("R4 R10 summaries", {sum_crit, sum_noncrit, sum_notif}, {is_c, is_n, is_t});
               check("R7 R9 R10 state at first edge", state, is_n ? 2'd1 : 2'd0);
               check("R7 irq", irq, is_n);
               check("R8 R10 float at first edge", io_float, (f == 1) && (is_n || is_t));
               @(negedge clk);
               // two edges after error
               check("R5 state", state, is_c ? 2'd2 : (is_n ? 2'd1 : 2'd0));
               check("R6 rst_req", rst_req, is_c);
               check("R6 rst_flag", rst_flag, is_c);
               check("R6 hb_en", hb_en, !is_c);
               check("R6 R8 io_float", io_float, is_c || ((f == 1) && (is_n || is_t)));
               clear_all();
               check("R3 esf cleared", esf, 0);
               @(negedge clk);
               check("R11 R6 state after clear", state, is_c ? 2'd2 : 2'd0);
               check("R11 irq after clear", irq, 0);
               check("R8 float latched", io_float, is_c || ((f == 1) && (is_n || is_t)));
               check("R4 summaries sticky", {sum_crit, sum_noncrit, sum_notif}, {is_c, is_n, is_t});
               check("R6 rst_flag sticky", rst_flag, is_c);
            end
         end
      end

      // R3: set wins over clear in the same cycle
      do_reset();
      @(negedge clk);
      err_in = 4'b0010; clr_we = 1'b1; clr_mask = 4'b0011;
      @(negedge clk);
      err_in = '0; clr_we = 1'b0; clr_mask = '0;
      check("R3 set beats clear", esf, 4'b0010);

      // R12: critical while in ALARM, then noncritical in FAULT
      do_reset();
      write_cfg(0, 2'b10, 1'b0);
      write_cfg(1, 2'b00, 1'b0);
      pulse(4'b0001);
      check("R12 alarm first", state, 2'd1);
      pulse(4'b0010);
      check("R12 crit in alarm holds one edge", state, 2'd1);
      @(negedge clk);
      check("R12 crit in alarm -> fault", state, 2'd2);
      clear_all();
      pulse(4'b0001);
      @(negedge clk);
      check("R12 noncrit in fault stays", state, 2'd2);
      check("R12 irq low in fault", irq, 0);

      // R12: simultaneous critical and noncritical
      do_reset();
      write_cfg(0, 2'b10, 1'b0);
      write_cfg(1, 2'b00, 1'b0);
      pulse(4'b0011);
      check("R12 simultaneous skips alarm", state, 2'd0);
      check("R12 simultaneous irq", irq, 0);
      @(negedge clk);
      check("R12 simultaneous -> fault", state, 2'd2);

      // R11: alarm stays while another noncritical flag remains
      do_reset();
      write_cfg(0, 2'b10, 1'b0);
      write_cfg(2, 2'b10, 1'b0);
      pulse(4'b0101);
      @(negedge clk);
      clr_we = 1'b1; clr_mask = 4'b0001;
      @(negedge clk);
      clr_we = 1'b0; clr_mask = '0;
      @(negedge clk);
      check("R11 partial clear keeps alarm", state, 2'd1);
      clear_all();
      @(negedge clk);
      check("R11 full clear -> normal", state, 2'd0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule